// File: doc/BRIEF.md
# Flash Command Entry Generator

This block turns one flash operation descriptor into the ordered list of 20-bit command entries that a serial-flash sequencer consumes. A descriptor names an opcode, an address value with its byte count, a dummy byte count, a data length with its direction, and a lane width for each of the command, address, dummy and data phases. The generator emits, in order, a chip-select assert entry, the opcode entry, one entry per address byte, an optional dummy-clock entry, a run of data-length entries and a chip-select release entry.

Entries leave through a valid/ready port into the sequencer's command FIFO. The port stalls while the FIFO refuses entries. Long data lengths are cut into power-of-two exponent entries followed by one immediate entry. Dummy bytes are turned into a count of clock cycles for the chosen lane width. A one-cycle done pulse marks the moment the release entry has been taken. The data bytes themselves never pass through this block.

Top module: `flash_cmd_seq`

## Requirements
- R1: `op_ready` is high only while the generator is idle. A descriptor is taken on a clock edge where `op_valid` and `op_ready` are both high, and its fields are held for the whole sequence. Descriptor input changes and `op_valid` pulses while busy have no effect.
- R2: Entry layout: immediate [7:0], transfer flag bit 8, exponent flag bit 9, lane mode [11:10], lower chip-select bit 12, upper chip-select bit 13 (always 0), lower bus bit 14, upper bus bit 15 (always 0), transmit bit 16, receive bit 17, bits 19:18 zero. The first entry of every sequence is chip-select assert: lower bus, lower chip-select, mode 01, immediate 5.
- R3: The second entry is the opcode entry: lower bus and chip-select, transmit set, transfer clear, command-phase lane mode, opcode in the immediate.
- R4: One transmit entry follows per address byte, most significant byte first, with the address-phase lane mode. A byte count of 0 gives no address entries. Counts above `ADDR_W/8` are clamped to `ADDR_W/8`.
- R5: Lane width 1 encodes as mode 01, width 2 as 10 and width 4 as 11. Every other width encodes as 01 and is treated as one lane.
- R6: A nonzero dummy byte count adds one entry with transfer set, transmit and receive clear, the dummy-phase mode, and immediate = dummy_bytes*8/lanes. A zero count adds no entry.
- R7: While the remaining data length exceeds 255, each data entry has the exponent flag set and carries the position p of the lowest set length bit at or above bit 8. Each such entry removes 2^p from the remaining length.
- R8: A remaining length of 1..255 gives one final data entry with the exponent flag clear and the length in the immediate. A remainder of 0 gives no entry. Direction codes are 01 receive and 10 transmit; codes 00 and 11, or a length of 0, give no data entries. Data entries set transfer plus transmit (bit 16) or receive (bit 17) and use the data-phase mode.
- R9: For receive, the final immediate is rounded up to a multiple of 4. A remainder of 253..255, which rounds to 256, is instead emitted as an exponent entry with p = 8.
- R10: The last entry is chip-select release: lower bus set, chip-select clear, mode 00, immediate 5. `done` pulses high for exactly one cycle, in the cycle after the release entry is taken, and `op_ready` is high again in that same cycle.
- R11: While `ent_valid` is high and `ent_ready` is low, `ent_valid` and `ent_data` stay unchanged. The first entry appears two clock edges after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Descriptor offered |
| op_ready | output | 1 | Generator idle, descriptor can be taken |
| op_opcode | input | 8 | Flash opcode |
| op_cmd_width | input | 3 | Command phase lane width |
| op_addr | input | ADDR_W | Address value |
| op_addr_bytes | input | ACNT_W | Number of address bytes |
| op_addr_width | input | 3 | Address phase lane width |
| op_dummy_bytes | input | DUMMY_W | Number of dummy bytes |
| op_dummy_width | input | 3 | Dummy phase lane width |
| op_len | input | LEN_W | Data length in bytes |
| op_dir | input | 2 | Data direction: 01 receive, 10 transmit, else none |
| op_data_width | input | 3 | Data phase lane width |
| ent_valid | output | 1 | Command entry valid |
| ent_ready | input | 1 | Command FIFO can take the entry |
| ent_data | output | 20 | Command entry |
| done | output | 1 | One-cycle pulse after the release entry is taken |

## Verification
The first entry is registered two edges after the accepting edge. Each following entry is registered on the same edge that consumes the previous one, and `done` is registered on the edge that consumes the release entry. The bench therefore samples at falling edges. It chooses `ent_ready` for the coming rising edge first, then records an entry exactly when `ent_valid` and that `ready` are both high, and expects `done` at the falling edge right after the release entry is recorded. The bench builds the expected entry list arithmetically, with its own exponent and rounding arithmetic. It compares that list entry by entry over a sweep of every data length from 0 to 300 in both directions, selected large lengths, all lane widths and all address counts, with and without back-pressure.

// File: rtl/flseq_pkg.sv
package flseq_pkg;

  localparam int ENT_W   = 20;
  localparam int B_XFER  = 8;
  localparam int B_EXP   = 9;
  localparam int B_MODE  = 10;
  localparam int B_CSLO  = 12;
  localparam int B_BUSLO = 14;
  localparam int B_TX    = 16;
  localparam int B_RX    = 17;

  localparam logic [7:0] CS_SETTLE = 8'd5;

  typedef enum logic [2:0] {
    K_CS_ON, K_CMD, K_ADDR, K_DUMMY, K_DATA, K_CS_OFF
  } ent_kind_t;

  typedef enum logic [1:0] {
    DIR_NONE = 2'b00,
    DIR_RX   = 2'b01,
    DIR_TX   = 2'b10,
    DIR_RSVD = 2'b11
  } dir_t;

  // lane count to the two-bit mode code; unknown widths act as one lane
  function automatic logic [1:0] lane_mode(input logic [2:0] w);
    case (w)
      3'd2:    lane_mode = 2'b10;
      3'd4:    lane_mode = 2'b11;
      default: lane_mode = 2'b01;
    endcase
  endfunction

  // log2 of the lane count for a mode code
  function automatic logic [1:0] lane_shift(input logic [1:0] m);
    case (m)
      2'b11:   lane_shift = 2'd2;
      2'b10:   lane_shift = 2'd1;
      default: lane_shift = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/flseq_len_split.sv
module flseq_len_split #(
  parameter int LEN_W = 16
) (
  input  logic [LEN_W-1:0] rem,
  input  logic             rx,
  output logic             use_exp,
  output logic [7:0]       imm,
  output logic [LEN_W-1:0] nxt_rem
);

  logic             big;
  logic [7:0]       low;
  logic [7:0]       rnd;
  logic [7:0]       pos;

  assign big = |rem[LEN_W-1:8];
  assign low = rem[7:0];
  assign rnd = low + 8'd3;

  always_comb begin
    pos = 8'd8;
    for (int b = LEN_W - 1; b >= 8; b--) begin
      if (rem[b]) pos = 8'(b);
    end
  end

  always_comb begin
    use_exp = 1'b0;
    imm     = low;
    nxt_rem = '0;
    if (big) begin
      use_exp      = 1'b1;
      imm          = pos;
      nxt_rem      = rem;
      nxt_rem[pos] = 1'b0;
    end else if (rx) begin
      if (low > 8'd252) begin
        use_exp = 1'b1;
        imm     = 8'd8;
      end else begin
        imm = {rnd[7:2], 2'b00};
      end
    end
  end

endmodule

// File: rtl/flseq_entry_fmt.sv
module flseq_entry_fmt
  import flseq_pkg::*;
(
  input  ent_kind_t        kind,
  input  logic [1:0]       mode,
  input  logic [7:0]       imm,
  input  logic             use_exp,
  input  logic             rx,
  output logic [ENT_W-1:0] ent
);

  always_comb begin
    ent            = '0;
    ent[B_BUSLO]   = 1'b1;
    ent[B_CSLO]    = (kind != K_CS_OFF);
    case (kind)
      K_CS_ON: begin
        ent[B_MODE +: 2] = 2'b01;
        ent[7:0]         = CS_SETTLE;
      end
      K_CMD, K_ADDR: begin
        ent[B_MODE +: 2] = mode;
        ent[B_TX]        = 1'b1;
        ent[7:0]         = imm;
      end
      K_DUMMY: begin
        ent[B_MODE +: 2] = mode;
        ent[B_XFER]      = 1'b1;
        ent[7:0]         = imm;
      end
      K_DATA: begin
        ent[B_MODE +: 2] = mode;
        ent[B_XFER]      = 1'b1;
        ent[B_EXP]       = use_exp;
        ent[B_TX]        = ~rx;
        ent[B_RX]        = rx;
        ent[7:0]         = imm;
      end
      default: begin
        ent[7:0] = CS_SETTLE;
      end
    endcase
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flseq_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 16,
  parameter int DUMMY_W = 5,
  localparam int ACNT_W = $clog2(ADDR_W / 8 + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               op_valid,
  output logic               op_ready,
  input  logic [7:0]         op_opcode,
  input  logic [2:0]         op_cmd_width,
  input  logic [ADDR_W-1:0]  op_addr,
  input  logic [ACNT_W-1:0]  op_addr_bytes,
  input  logic [2:0]         op_addr_width,
  input  logic [DUMMY_W-1:0] op_dummy_bytes,
  input  logic [2:0]         op_dummy_width,
  input  logic [LEN_W-1:0]   op_len,
  input  logic [1:0]         op_dir,
  input  logic [2:0]         op_data_width,
  output logic               ent_valid,
  input  logic               ent_ready,
  output logic [ENT_W-1:0]   ent_data,
  output logic               done
);

  localparam int MAXB = ADDR_W / 8;
  localparam int DB_W = DUMMY_W + 3;
  localparam logic [ENT_W-1:0] CS_ON_VAL =
    ENT_W'((1 << B_BUSLO) | (1 << B_CSLO) | (1 << B_MODE) | 5);

  typedef enum logic [2:0] {
    S_IDLE, S_CS_ON, S_CMD, S_ADDR, S_DUMMY, S_DATA, S_CS_OFF, S_DRAIN
  } state_t;

  state_t             st;
  logic [7:0]         opc_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [ACNT_W-1:0]  acnt_q;
  logic [ACNT_W-1:0]  aidx_q;
  logic [1:0]         cmd_m_q, addr_m_q, dum_m_q, dat_m_q;
  logic [7:0]         dcyc_q;
  logic [LEN_W-1:0]   rem_q;
  logic               rx_q;

  // descriptor decode at acceptance
  logic [ACNT_W-1:0]  acnt_in;
  logic [DB_W-1:0]    dbits;
  logic               dir_ok;

  assign acnt_in = (op_addr_bytes > ACNT_W'(MAXB)) ? ACNT_W'(MAXB) : op_addr_bytes;
  assign dbits   = {op_dummy_bytes, 3'b000} >> lane_shift(lane_mode(op_dummy_width));
  assign dir_ok  = (op_dir == DIR_RX) || (op_dir == DIR_TX);

  // phase skipping
  state_t after_dummy, after_addr, after_cmd;
  assign after_dummy = (rem_q != '0)  ? S_DATA  : S_CS_OFF;
  assign after_addr  = (dcyc_q != '0) ? S_DUMMY : after_dummy;
  assign after_cmd   = (acnt_q != '0) ? S_ADDR  : after_addr;

  // data length split
  logic             sp_exp;
  logic [7:0]       sp_imm;
  logic [LEN_W-1:0] sp_nxt;

  flseq_len_split #(.LEN_W(LEN_W)) u_split (
    .rem     (rem_q),
    .rx      (rx_q),
    .use_exp (sp_exp),
    .imm     (sp_imm),
    .nxt_rem (sp_nxt)
  );

  // entry field selection
  ent_kind_t         kind;
  logic [1:0]        mode;
  logic [7:0]        imm;
  logic [ADDR_W-1:0] addr_sh;
  logic [ENT_W-1:0]  ent_next;

  assign addr_sh = addr_q >> {aidx_q, 3'b000};

  always_comb begin
    kind = K_CS_OFF;
    mode = 2'b00;
    imm  = 8'd0;
    case (st)
      S_CS_ON: kind = K_CS_ON;
      S_CMD:   begin kind = K_CMD;   mode = cmd_m_q;  imm = opc_q;        end
      S_ADDR:  begin kind = K_ADDR;  mode = addr_m_q; imm = addr_sh[7:0]; end
      S_DUMMY: begin kind = K_DUMMY; mode = dum_m_q;  imm = dcyc_q;       end
      S_DATA:  begin kind = K_DATA;  mode = dat_m_q;  imm = sp_imm;       end
      default: kind = K_CS_OFF;
    endcase
  end

  flseq_entry_fmt u_fmt (
    .kind    (kind),
    .mode    (mode),
    .imm     (imm),
    .use_exp (sp_exp),
    .rx      (rx_q),
    .ent     (ent_next)
  );

  logic slot_free;
  assign slot_free = !ent_valid || ent_ready;
  assign op_ready  = (st == S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      ent_valid <= 1'b0;
      ent_data  <= '0;
      done      <= 1'b0;
      opc_q     <= '0;
      addr_q    <= '0;
      acnt_q    <= '0;
      aidx_q    <= '0;
      cmd_m_q   <= '0;
      addr_m_q  <= '0;
      dum_m_q   <= '0;
      dat_m_q   <= '0;
      dcyc_q    <= '0;
      rem_q     <= '0;
      rx_q      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (op_valid) begin
            opc_q    <= op_opcode;
            addr_q   <= op_addr;
            acnt_q   <= acnt_in;
            cmd_m_q  <= lane_mode(op_cmd_width);
            addr_m_q <= lane_mode(op_addr_width);
            dum_m_q  <= lane_mode(op_dummy_width);
            dat_m_q  <= lane_mode(op_data_width);
            dcyc_q   <= 8'(dbits);
            rem_q    <= dir_ok ? op_len : '0;
            rx_q     <= (op_dir == DIR_RX);
            st       <= S_CS_ON;
          end
        end
        S_DRAIN: begin
          if (ent_ready) begin
            ent_valid <= 1'b0;
            done      <= 1'b1;
            st        <= S_IDLE;
          end
        end
        default: begin
          if (slot_free) begin
            ent_valid <= 1'b1;
            ent_data  <= ent_next;
            case (st)
              S_CS_ON: st <= S_CMD;
              S_CMD: begin
                aidx_q <= acnt_q - 1'b1;
                st     <= after_cmd;
              end
              S_ADDR: begin
                if (aidx_q == '0) st <= after_addr;
                else aidx_q <= aidx_q - 1'b1;
              end
              S_DUMMY: st <= after_dummy;
              S_DATA: begin
                rem_q <= sp_nxt;
                if (sp_nxt == '0) st <= S_CS_OFF;
              end
              default: st <= S_DRAIN;
            endcase
          end
        end
      endcase
    end
  end

  // R11: an offered entry is held until taken
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    ent_valid && !ent_ready |=> ent_valid && $stable(ent_data));

  // R1: no new descriptor while an entry is outstanding
  p_busy_r1: assert property (@(posedge clk) disable iff (rst)
    ent_valid |-> !op_ready);

  // R2: acceptance leads to chip-select assert two edges later
  p_first_cs_r2: assert property (@(posedge clk) disable iff (rst)
    op_valid && op_ready |=> !ent_valid ##1 (ent_valid && ent_data == CS_ON_VAL));

  // R10: done follows the release entry and reopens the input
  p_done_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !ent_valid && op_ready && !$past(ent_data[B_CSLO]) && $past(ent_data[7:0]) == CS_SETTLE);

  // R7: exponent entries are data transfers with a position of 8 or more
  p_exp_r7: assert property (@(posedge clk) disable iff (rst)
    ent_valid && ent_data[B_EXP] |-> ent_data[B_XFER] && ent_data[7:0] >= 8'd8);

  // R9: receive immediates are word multiples
  p_rxround_r9: assert property (@(posedge clk) disable iff (rst)
    ent_valid && ent_data[B_RX] && !ent_data[B_EXP] |-> ent_data[1:0] == 2'b00);

  // R5: selected entries never carry mode 00
  p_mode_r5: assert property (@(posedge clk) disable iff (rst)
    ent_valid && ent_data[B_CSLO] |-> ent_data[B_MODE +: 2] != 2'b00);

endmodule

// File: tb/tb_flash_cmd_seq.sv
module tb_flash_cmd_seq;

  localparam int ADDR_W  = 32;
  localparam int LEN_W   = 16;
  localparam int DUMMY_W = 5;
  localparam int ACNT_W  = 3;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               op_valid = 1'b0;
  logic               op_ready;
  logic [7:0]         op_opcode = '0;
  logic [2:0]         op_cmd_width = '0;
  logic [ADDR_W-1:0]  op_addr = '0;
  logic [ACNT_W-1:0]  op_addr_bytes = '0;
  logic [2:0]         op_addr_width = '0;
  logic [DUMMY_W-1:0] op_dummy_bytes = '0;
  logic [2:0]         op_dummy_width = '0;
  logic [LEN_W-1:0]   op_len = '0;
  logic [1:0]         op_dir = '0;
  logic [2:0]         op_data_width = '0;
  logic               ent_valid;
  logic               ent_ready = 1'b0;
  logic [19:0]        ent_data;
  logic               done;

  always #2.5 clk = ~clk;

  flash_cmd_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DUMMY_W(DUMMY_W)) dut (
    .clk, .rst, .op_valid, .op_ready, .op_opcode, .op_cmd_width, .op_addr,
    .op_addr_bytes, .op_addr_width, .op_dummy_bytes, .op_dummy_width,
    .op_len, .op_dir, .op_data_width, .ent_valid, .ent_ready, .ent_data, .done
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [19:0] exp_q [0:63];
  int n_exp;
  logic [7:0] lf = 8'hA5;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic int mode_of(input int w);
    return (w == 4) ? 3 : (w == 2) ? 2 : 1;
  endfunction

  function automatic int lanes_of(input int m);
    return (m == 3) ? 4 : (m == 2) ? 2 : 1;
  endfunction

  function automatic void push(input int v);
    exp_q[n_exp] = 20'(v);
    n_exp++;
  endfunction

  localparam int SEL = (1 << 14) | (1 << 12);

  function automatic void build(input int opc, input int cw, input longint av, input int ab,
                                input int aw, input int db, input int dw, input int len,
                                input int dir, input int xw);
    int nb, r, p, m, dbit, q;
    n_exp = 0;
    push(SEL | (1 << 10) | 5);                                   // R2
    push(SEL | (mode_of(cw) << 10) | (1 << 16) | opc);           // R3
    nb = (ab > 4) ? 4 : ab;
    for (int i = nb - 1; i >= 0; i--)                             // R4
      push(SEL | (mode_of(aw) << 10) | (1 << 16) | int'((av >> (8 * i)) & 255));
    if (db != 0)                                                  // R6
      push(SEL | (mode_of(dw) << 10) | (1 << 8) | ((db * 8 / lanes_of(mode_of(dw))) & 255));
    if ((dir == 1 || dir == 2) && len != 0) begin                 // R7 R8 R9
      m = mode_of(xw);
      dbit = (dir == 1) ? (1 << 17) : (1 << 16);
      r = len;
      while (r > 255) begin
        p = 8;
        while (((r >> p) & 1) == 0) p++;
        push(SEL | (m << 10) | dbit | (1 << 8) | (1 << 9) | p);
        r = r - (1 << p);
      end
      if (r != 0) begin
        if (dir == 1) begin
          q = ((r + 3) / 4) * 4;
          if (q == 256) push(SEL | (m << 10) | dbit | (1 << 8) | (1 << 9) | 8);
          else push(SEL | (m << 10) | dbit | (1 << 8) | q);
        end else begin
          push(SEL | (m << 10) | dbit | (1 << 8) | r);
        end
      end
    end
    push((1 << 14) | 5);                                          // R10
  endfunction

  task automatic run_op(input int opc, input int cw, input logic [31:0] av, input int ab,
                        input int aw, input int db, input int dw, input int len,
                        input int dir, input int xw, input bit noise, input bit stall);
    int idx, cyc;
    bit got_done, prev_hold;
    logic [19:0] prev_data;
    build(opc, cw, {32'd0, av}, ab, aw, db, dw, len, dir, xw);
    @(negedge clk);
    op_opcode = 8'(opc); op_cmd_width = 3'(cw); op_addr = av; op_addr_bytes = 3'(ab);
    op_addr_width = 3'(aw); op_dummy_bytes = 5'(db); op_dummy_width = 3'(dw);
    op_len = 16'(len); op_dir = 2'(dir); op_data_width = 3'(xw);
    op_valid = 1'b1;
    chk(op_ready == 1'b1, "R1 ready when idle", 32'(op_ready), 1);
    @(negedge clk);
    op_valid = noise;
    if (noise) begin  // R1: altered fields while busy must not matter
      op_opcode = ~op_opcode; op_addr = ~op_addr; op_addr_bytes = 3'd1;
      op_dummy_bytes = 5'd7; op_len = 16'd9; op_dir = 2'b10; op_cmd_width = 3'd4;
    end
    chk(op_ready == 1'b0, "R1 busy after accept", 32'(op_ready), 0);
    idx = 0; cyc = 0; got_done = 0; prev_hold = 0; prev_data = '0;
    while (!got_done && cyc < 4000) begin
      if (done) begin
        got_done = 1;
      end else begin
        ent_ready = stall ? (lf[0] | lf[2]) : 1'b1;
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        if (prev_hold)
          chk(ent_valid && ent_data == prev_data, "R11 held while stalled", {12'd0, ent_data}, {12'd0, prev_data});
        if (ent_valid && ent_ready) begin
          if (idx < n_exp)
            chk(ent_data == exp_q[idx], $sformatf("R2-R10 entry %0d len=%0d dir=%0d", idx, len, dir),
                {12'd0, ent_data}, {12'd0, exp_q[idx]});
          else
            chk(1'b0, "R10 extra entry", {12'd0, ent_data}, 0);
          idx++;
          if (idx >= n_exp) op_valid = 1'b0;
        end
        prev_hold = ent_valid && !ent_ready;
        prev_data = ent_data;
        @(negedge clk);
        cyc++;
      end
    end
    op_valid = 1'b0;
    chk(got_done, "R10 done seen", 32'(got_done), 1);
    chk(idx == n_exp, "R10 entry count at done", 32'(idx), 32'(n_exp));
    chk(op_ready && !ent_valid, "R10 idle with done", {30'd0, op_ready, ent_valid}, 32'h2);
    ent_ready = 1'b1;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      chk(!done, "R10 done is one cycle", 32'(done), 0);
      chk(!ent_valid && op_ready, "R1 no extra sequence", {30'd0, op_ready, ent_valid}, 32'h2);
    end
  endtask

  initial begin
    #900us;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ent_valid == 1'b0 && done == 1'b0, "R10 reset outputs", {30'd0, ent_valid, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(op_ready == 1'b1, "R1 ready after reset", 32'(op_ready), 1);

    // R3 R4 R5 R6: all lane widths, address counts, dummy sizes
    for (int cw = 0; cw < 8; cw++)
      for (int ab = 0; ab < 8; ab++)
        run_op(8'h0B ^ (cw * 17), cw, 32'hA1B2C3D4 + cw, ab, (cw + 3) % 8,
               (cw * 3 + ab) % 32, (cw + ab) % 8, 0, 0, 1, (ab == 2), ab[0]);

    // R7 R8 R9: every length 0..300 in both directions
    for (int l = 0; l <= 300; l++) begin
      run_op(8'h6B, 1, 32'h00123456, 3, 1, 1, 2, l, 1, (l % 5), (l % 7 == 0), l[0]);
      run_op(8'h32, 4, 32'h00ABCDEF, 3, 4, 0, 1, l, 2, (l % 6), 1'b0, l[1]);
    end

    // R7 R9: large lengths
    begin
      int big [12] = '{511, 512, 767, 1000, 1021, 1024, 4096, 4351, 32768, 40000, 65533, 65535};
      foreach (big[i]) begin
        run_op(8'hEB, 1, 32'h01020304, 4, 4, 4, 4, big[i], 1, 4, 1'b1, 1'b1);
        run_op(8'h02, 1, 32'h01020304, 3, 1, 0, 1, big[i], 2, 2, 1'b0, 1'b1);
      end
    end

    // R8: no-data direction codes
    run_op(8'h05, 1, 32'h0, 0, 1, 0, 1, 500, 0, 1, 1'b0, 1'b0);
    run_op(8'h9F, 1, 32'h0, 0, 1, 2, 1, 500, 3, 1, 1'b0, 1'b1);

    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule